// File: doc/BRIEF.md
# Timestamped Output Event Scheduler

This block sits between a processor-side write port and one real-time output channel. The processor hands it events, each a 64-bit timestamp in machine units (nominally 1 ns) paired with a data word. Accepted events wait in a first-in first-out queue. Each event is released on the channel in the coarse clock cycle that contains its timestamp. The block runs on the coarse clock, and one coarse cycle spans 8 machine units. An internal wall clock starts at zero on reset and advances by 8 machine units on every cycle. The low 3 bits of a timestamp are the fine position within the coarse cycle. They leave the block with the fired data so that a downstream serialiser can place the edge inside the cycle.

Every submission is checked when it is taken. A timestamp too close to the present is refused as an underflow. A timestamp in the same or an earlier coarse cycle than the newest queued event is discarded as a collision. An exact repeat of the newest queued timestamp may instead overwrite that event's data, if replacement is enabled. Once an event has fired, the channel is busy for a set number of cycles, and an event that comes due in that window is dropped as a busy error. The three error kinds are held in sticky flags. Each flag is cleared by writing a one to its bit of a clear input. Errors never stop later events from being accepted. A full queue deasserts ready instead of raising an error.

Top module: `evt_sched`

## Requirements
- R1: While reset is held, `wall_mu` is 0. After reset is released, `wall_mu` grows by exactly 8 on every clock cycle.
- R2: A taken submission whose coarse timestamp (`sub_ts[63:3]`) is not greater than `wall_mu[63:3] + 1` is refused. It is not queued, never fires, and sets underflow flag `err_flags[0]`.
- R3: A queued event that is not dropped drives `fire_valid` high for one cycle. That cycle is the one in which `wall_mu[63:3]` equals its coarse timestamp. `fire_data` carries the event data and `fire_fine` carries `sub_ts[2:0]`. The event never fires earlier.
- R4: Events fire in the order in which they were accepted.
- R5: A submission taken while `replace_en` is 1 and the queue is not empty, whose timestamp exactly equals the newest queued timestamp, overwrites that event's data. No entry is added and no error flag is set.
- R6: Any other submission taken while the queue is not empty, whose coarse timestamp is not greater than that of the newest queued event, is discarded and sets collision flag `err_flags[1]`. This includes an exact repeat taken while `replace_en` is 0.
- R7: `sub_ready` is 0 while the queue holds DEPTH events (default 8), and a submission offered then is not taken.
- R8: After an event fires, any event whose coarse timestamp is 1 to EXEC_CYC-1 cycles later (EXEC_CYC defaults to 3) is dropped without firing, and sets busy flag `err_flags[2]`.
- R9: Error flags stay set until a cycle in which the matching bit of `err_clr` is 1. A new error in that same cycle wins over the clear.
- R10: After any error, a later well-timed submission is still accepted and fires normally.
- R11: Reset empties the queue and clears all error flags. Events queued before reset never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_valid | input | 1 | Submission offered |
| sub_ready | output | 1 | Queue can take a submission |
| sub_ts | input | 64 | Event timestamp in machine units |
| sub_data | input | DATA_W | Event data |
| replace_en | input | 1 | Exact-timestamp repeat overwrites instead of colliding |
| err_clr | input | 3 | Write-one-to-clear for the error flags |
| err_flags | output | 3 | Sticky flags: [0] underflow, [1] collision, [2] busy |
| wall_mu | output | 64 | Wall clock in machine units |
| fire_valid | output | 1 | Event released this cycle |
| fire_data | output | DATA_W | Data of the released event |
| fire_fine | output | 3 | Fine position of the released event within the cycle |

## Verification
The bound checker watches the per-cycle laws on every cycle: the wall clock step, flag setting after each refusal or drop, flag persistence until it is cleared, at most one admission outcome per cycle, no admission while ready is low, a fire output after every accepted release, and clean flags as reset ends. Whether an event fires in exactly the coarse cycle of its own timestamp can only be seen in the bench's scenarios, which compare fire times against timestamps they computed themselves. The same holds for data replacement, fire order, the busy window after a fire, and the loss of queued events across reset.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
  localparam int TS_W   = 64;
  localparam int FINE_W = 3;
  localparam int CRS_W  = TS_W - FINE_W;
  localparam logic [TS_W-1:0] MU_PER_CYC = TS_W'(1) << FINE_W;

  typedef enum int {
    ERR_UNDERFLOW = 0,
    ERR_COLLISION = 1,
    ERR_BUSY      = 2
  } err_idx_e;
  localparam int ERR_N = 3;

  function automatic logic [CRS_W-1:0] coarse_of(input logic [TS_W-1:0] ts);
    return ts[TS_W-1:FINE_W];
  endfunction

  // earliest coarse cycle that can still be hit: two cycles ahead of now
  function automatic logic too_late(input logic [TS_W-1:0] ts,
                                    input logic [TS_W-1:0] wall);
    return coarse_of(ts) <= coarse_of(wall) + CRS_W'(1);
  endfunction
endpackage

// File: rtl/evt_wallclock.sv
module evt_wallclock
  import evt_sched_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] wall
);
  always_ff @(posedge clk) begin
    if (rst) wall <= '0;
    else     wall <= wall + MU_PER_CYC;
  end
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int W     = 80,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         rewrite,
  input  logic [W-1:0] rwdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [W-1:0] newest,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, nw_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign nw_ptr = (wr_ptr == '0) ? LAST : wr_ptr - AW'(1);
  assign head   = mem[rd_ptr];
  assign newest = mem[nw_ptr];
  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push)    mem[wr_ptr] <= wdata;
    if (rewrite) mem[nw_ptr] <= rwdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/evt_admit.sv
module evt_admit
  import evt_sched_pkg::*;
(
  input  logic            take,
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] wall,
  input  logic            replace_en,
  input  logic            have_last,
  input  logic [TS_W-1:0] last_ts,
  output logic            do_push,
  output logic            do_replace,
  output logic            is_underflow,
  output logic            is_collision
);
  logic late, exact, not_after;

  always_comb begin
    late      = too_late(ts, wall);
    exact     = have_last && (ts == last_ts);
    not_after = have_last && (coarse_of(ts) <= coarse_of(last_ts));

    is_underflow = take && late;
    do_replace   = take && !late && exact && replace_en;
    is_collision = take && !late && not_after && !(exact && replace_en);
    do_push      = take && !late && !not_after;
  end
endmodule

// File: rtl/evt_fire.sv
module evt_fire
  import evt_sched_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int EXEC_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_valid,
  input  logic [TS_W-1:0]   head_ts,
  input  logic [DATA_W-1:0] head_data,
  input  logic [TS_W-1:0]   wall,
  output logic              pop,
  output logic              release_now,
  output logic              drop_busy,
  output logic              fire_valid,
  output logic [DATA_W-1:0] fire_data,
  output logic [FINE_W-1:0] fire_fine
);
  localparam int BW = $clog2(EXEC_CYC + 1);
  localparam logic [BW-1:0] HOLD = BW'(EXEC_CYC - 1);

  logic [BW-1:0] busy_cnt;
  logic          due;

  // decide one cycle ahead so the registered output lands in the due cycle
  assign due         = head_valid && (coarse_of(head_ts) <= coarse_of(wall) + CRS_W'(1));
  assign pop         = due;
  assign release_now = due && (busy_cnt == '0);
  assign drop_busy   = due && (busy_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_valid <= 1'b0;
      fire_data  <= '0;
      fire_fine  <= '0;
      busy_cnt   <= '0;
    end else begin
      fire_valid <= release_now;
      if (release_now) begin
        fire_data <= head_data;
        fire_fine <= head_ts[FINE_W-1:0];
        busy_cnt  <= HOLD;
      end else if (busy_cnt != '0) begin
        busy_cnt <= busy_cnt - BW'(1);
      end
    end
  end
endmodule

// File: rtl/evt_sched.sv
module evt_sched
  import evt_sched_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 8,
  parameter int EXEC_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_valid,
  output logic              sub_ready,
  input  logic [63:0]       sub_ts,
  input  logic [DATA_W-1:0] sub_data,
  input  logic              replace_en,
  input  logic [2:0]        err_clr,
  output logic [2:0]        err_flags,
  output logic [63:0]       wall_mu,
  output logic              fire_valid,
  output logic [DATA_W-1:0] fire_data,
  output logic [2:0]        fire_fine
);
  localparam int ENT_W = TS_W + DATA_W;

  logic [TS_W-1:0]  wall;
  logic [ENT_W-1:0] head_ent, newest_ent;
  logic             q_empty, q_full;
  logic             take, acc_push, acc_replace, ev_underflow, ev_collision;
  logic             pop_any, pop_fire, busy_drop;
  logic [ERR_N-1:0] err_q, err_set;

  evt_wallclock u_clk (.clk(clk), .rst(rst), .wall(wall));

  assign take      = sub_valid && sub_ready;
  assign sub_ready = !q_full;

  evt_admit u_admit (
    .take(take), .ts(sub_ts), .wall(wall), .replace_en(replace_en),
    .have_last(!q_empty), .last_ts(newest_ent[ENT_W-1:DATA_W]),
    .do_push(acc_push), .do_replace(acc_replace),
    .is_underflow(ev_underflow), .is_collision(ev_collision)
  );

  evt_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(acc_push), .wdata({sub_ts, sub_data}),
    .rewrite(acc_replace), .rwdata({sub_ts, sub_data}),
    .pop(pop_any), .head(head_ent), .newest(newest_ent),
    .empty(q_empty), .full(q_full)
  );

  evt_fire #(.DATA_W(DATA_W), .EXEC_CYC(EXEC_CYC)) u_fire (
    .clk(clk), .rst(rst), .head_valid(!q_empty),
    .head_ts(head_ent[ENT_W-1:DATA_W]), .head_data(head_ent[DATA_W-1:0]),
    .wall(wall), .pop(pop_any), .release_now(pop_fire), .drop_busy(busy_drop),
    .fire_valid(fire_valid), .fire_data(fire_data), .fire_fine(fire_fine)
  );

  always_comb begin
    err_set                = '0;
    err_set[ERR_UNDERFLOW] = ev_underflow;
    err_set[ERR_COLLISION] = ev_collision;
    err_set[ERR_BUSY]      = busy_drop;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (err_q & ~err_clr) | err_set;
  end

  assign err_flags = err_q;
  assign wall_mu   = wall;
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk (
  input logic        clk,
  input logic        rst,
  input logic [63:0] wall_mu,
  input logic        sub_ready,
  input logic [2:0]  err_flags,
  input logic [2:0]  err_clr,
  input logic        fire_valid,
  input logic        ev_underflow,
  input logic        ev_collision,
  input logic        acc_push,
  input logic        acc_replace,
  input logic        busy_drop,
  input logic        pop_fire
);
  assert_wall_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wall_mu == $past(wall_mu) + 64'd8));

  assert_underflow_flag_R2: assert property (@(posedge clk) disable iff (rst)
    ev_underflow |=> err_flags[0]);

  assert_release_fires_R3: assert property (@(posedge clk) disable iff (rst)
    pop_fire |=> fire_valid);

  assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_underflow, ev_collision, acc_push, acc_replace}));

  assert_collision_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ev_collision |=> err_flags[1]);

  assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    !sub_ready |-> !(acc_push || acc_replace || ev_underflow || ev_collision));

  assert_busy_flag_R8: assert property (@(posedge clk) disable iff (rst)
    busy_drop |=> err_flags[2]);

  assert_sticky_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flags[0] && !err_clr[0]) |=> err_flags[0]);

  assert_sticky_collision_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flags[1] && !err_clr[1]) |=> err_flags[1]);

  assert_sticky_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flags[2] && !err_clr[2]) |=> err_flags[2]);

  assert_reset_clean_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (err_flags == 3'b000 && !fire_valid));
endmodule

bind evt_sched evt_sched_chk u_chk (
  .clk(clk), .rst(rst), .wall_mu(wall_mu), .sub_ready(sub_ready),
  .err_flags(err_flags), .err_clr(err_clr), .fire_valid(fire_valid),
  .ev_underflow(ev_underflow), .ev_collision(ev_collision),
  .acc_push(acc_push), .acc_replace(acc_replace),
  .busy_drop(busy_drop), .pop_fire(pop_fire)
);

// File: tb/evt_sched_tb.sv
`timescale 1ns/1ps
module evt_sched_tb;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sub_valid = 1'b0;
  logic          sub_ready;
  logic [63:0]   sub_ts = '0;
  logic [DW-1:0] sub_data = '0;
  logic          replace_en = 1'b0;
  logic [2:0]    err_clr = 3'b000;
  logic [2:0]    err_flags;
  logic [63:0]   wall_mu;
  logic          fire_valid;
  logic [DW-1:0] fire_data;
  logic [2:0]    fire_fine;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  evt_sched #(.DATA_W(DW), .DEPTH(DEPTH), .EXEC_CYC(3)) u_dut (
    .clk(clk), .rst(rst), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_ts(sub_ts), .sub_data(sub_data), .replace_en(replace_en),
    .err_clr(err_clr), .err_flags(err_flags), .wall_mu(wall_mu),
    .fire_valid(fire_valid), .fire_data(fire_data), .fire_fine(fire_fine)
  );

  // fire log, sampled mid-cycle
  int          nfired = 0;
  logic [63:0] log_cyc  [64];
  logic [DW-1:0] log_dat [64];
  logic [2:0]  log_fine [64];

  always @(negedge clk) begin
    if (!rst && fire_valid && nfired < 64) begin
      log_cyc[nfired]  = wall_mu >> 3;
      log_dat[nfired]  = fire_data;
      log_fine[nfired] = fire_fine;
      nfired = nfired + 1;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic submit_abs(input logic [63:0] ts, input logic [DW-1:0] d);
    @(negedge clk);
    sub_valid = 1'b1; sub_ts = ts; sub_data = d;
    @(negedge clk);
    sub_valid = 1'b0;
  endtask

  task automatic submit_rel(input int lead, input int fine, input logic [DW-1:0] d,
                            output logic [63:0] ts);
    @(negedge clk);
    ts = (((wall_mu >> 3) + 64'(lead)) << 3) | 64'(fine);
    sub_valid = 1'b1; sub_ts = ts; sub_data = d;
    @(negedge clk);
    sub_valid = 1'b0;
  endtask

  task automatic clear_err(input logic [2:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = 3'b000;
  endtask

  task automatic t_reset;
    logic [63:0] w0;
    check("R1 wall in reset", wall_mu, 64'd0);
    check("R11 flags in reset", {61'd0, err_flags}, 64'd0);
    check("R3 no fire in reset", {63'd0, fire_valid}, 64'd0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk) w0 = wall_mu;
    @(negedge clk) check("R1 wall step", wall_mu - w0, 64'd8);
    idle(3);
    check("R1 wall step x3", wall_mu - w0, 64'd32);
    check("R7 ready when empty", {63'd0, sub_ready}, 64'd1);
  endtask

  task automatic t_basic;
    logic [63:0] a, b, c;
    int s;
    s = nfired;
    submit_rel(5, 3, 16'h0A01, a);
    submit_rel(8, 0, 16'h0A02, b);
    submit_rel(10, 7, 16'h0A03, c);
    idle(20);
    check("R3 basic count", 64'(nfired - s), 64'd3);
    check("R3 cycle a", log_cyc[s],   a >> 3);
    check("R3 cycle b", log_cyc[s+1], b >> 3);
    check("R3 cycle c", log_cyc[s+2], c >> 3);
    check("R4 order a", 64'(log_dat[s]),   64'h0A01);
    check("R4 order b", 64'(log_dat[s+1]), 64'h0A02);
    check("R4 order c", 64'(log_dat[s+2]), 64'h0A03);
    check("R3 fine a", 64'(log_fine[s]),   64'd3);
    check("R3 fine c", 64'(log_fine[s+2]), 64'd7);
    check("R2 no spurious flags", {61'd0, err_flags}, 64'd0);
  endtask

  task automatic t_underflow;
    logic [63:0] t;
    int s;
    s = nfired;
    submit_rel(1, 7, 16'h0B01, t);
    check("R2 underflow at lead 1", {63'd0, err_flags[0]}, 64'd1);
    submit_rel(0, 0, 16'h0B02, t);
    idle(6);
    check("R2 refused never fires", 64'(nfired - s), 64'd0);
    check("R9 underflow sticky", {63'd0, err_flags[0]}, 64'd1);
    check("R2 ready kept", {63'd0, sub_ready}, 64'd1);
    submit_rel(2, 4, 16'h0B03, t);
    idle(5);
    check("R10 accepted after error", 64'(nfired - s), 64'd1);
    check("R10 fires on time", log_cyc[s], t >> 3);
    check("R10 data", 64'(log_dat[s]), 64'h0B03);
    clear_err(3'b010);
    check("R9 other bit untouched", {63'd0, err_flags[0]}, 64'd1);
    clear_err(3'b001);
    check("R9 cleared by write one", {61'd0, err_flags}, 64'd0);
  endtask

  task automatic t_replace;
    logic [63:0] t;
    int s;
    s = nfired;
    replace_en = 1'b1;
    submit_rel(6, 2, 16'h0C11, t);
    submit_abs(t, 16'h0C22);
    idle(10);
    check("R5 one event", 64'(nfired - s), 64'd1);
    check("R5 new data", 64'(log_dat[s]), 64'h0C22);
    check("R5 fine kept", 64'(log_fine[s]), 64'd2);
    check("R5 no error", {61'd0, err_flags}, 64'd0);
  endtask

  task automatic t_collision;
    logic [63:0] t;
    int s;
    s = nfired;
    replace_en = 1'b1;
    submit_rel(20, 1, 16'h0D33, t);
    submit_abs(t + 64'd2, 16'h0D44);
    check("R6 same coarse other fine", {63'd0, err_flags[1]}, 64'd1);
    clear_err(3'b010);
    replace_en = 1'b0;
    submit_abs(t, 16'h0D55);
    check("R6 exact repeat no replace", {63'd0, err_flags[1]}, 64'd1);
    clear_err(3'b010);
    submit_abs(t - 64'd8, 16'h0D66);
    check("R6 earlier coarse", {63'd0, err_flags[1]}, 64'd1);
    idle(30);
    check("R6 only first fires", 64'(nfired - s), 64'd1);
    check("R6 first data kept", 64'(log_dat[s]), 64'h0D33);
    clear_err(3'b111);
  endtask

  task automatic t_full;
    logic [63:0] t;
    int s;
    s = nfired;
    for (int i = 0; i < DEPTH; i++) submit_rel(40 + 4 * i, 0, 16'(16'h0E00 + i), t);
    check("R7 ready low when full", {63'd0, sub_ready}, 64'd0);
    @(negedge clk);
    sub_valid = 1'b1; sub_ts = t + 64'd800; sub_data = 16'h0EFF;
    idle(3);
    sub_valid = 1'b0;
    idle(100);
    check("R7 extra not taken", 64'(nfired - s), 64'(DEPTH));
    check("R7 last data", 64'(log_dat[s + DEPTH - 1]), 64'(16'h0E00 + DEPTH - 1));
    check("R7 no error", {61'd0, err_flags}, 64'd0);
    check("R7 ready back", {63'd0, sub_ready}, 64'd1);
  endtask

  task automatic t_busy;
    logic [63:0] t0;
    int s;
    s = nfired;
    submit_rel(6, 0, 16'h0FA1, t0);
    submit_abs(t0 + 64'd8, 16'h0FA2);
    submit_abs(t0 + 64'd24, 16'h0FA3);
    idle(15);
    check("R8 two fired", 64'(nfired - s), 64'd2);
    check("R8 first data", 64'(log_dat[s]), 64'h0FA1);
    check("R8 third data", 64'(log_dat[s+1]), 64'h0FA3);
    check("R8 third cycle", log_cyc[s+1], (t0 >> 3) + 64'd3);
    check("R8 busy flag", {61'd0, err_flags}, 64'd4);
    clear_err(3'b100);
  endtask

  task automatic t_reset_flush;
    logic [63:0] t;
    int s;
    s = nfired;
    submit_rel(1, 0, 16'h0001, t);
    submit_rel(15, 0, 16'h1B1, t);
    @(negedge clk) rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R11 flags cleared", {61'd0, err_flags}, 64'd0);
    idle(30);
    check("R11 queued event lost", 64'(nfired - s), 64'd0);
    check("R11 wall restarted", {63'd0, wall_mu < 64'd400}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    t_basic();
    t_underflow();
    t_replace();
    t_collision();
    t_full();
    t_busy();
    t_reset_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule